// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore Bank

This block gives two processor cores a shared set of sixteen hardware locks reached over a simple 32-bit register bus. Every lock records whether it is held and which bus master holds it. The owner is always taken from the master ID that comes with the access. The write data never supplies it. A core can take a lock in either of two ways, and both can be mixed freely on the same bank. It can write a take request and then read the same register back to see whether its own ID was recorded. It can also read a separate claim register, and that single read grabs the lock if it was free.

Each lock runs a two-state machine. In SEM_FREE, a take request (write or claim read) moves the lock to SEM_HELD and records the requester. In SEM_HELD, a release write from the recorded owner moves it back to SEM_FREE and clears the owner. All other requests leave it where it is. A release by core 1 flags that lock in core 2's interrupt status, and the reverse is also true. Each core has its own enable, status, masked-status and clear registers and its own interrupt line.

The bus port runs a two-state response machine, BUS_IDLE and BUS_RESP. A read accepted in any state moves it to BUS_RESP for the next cycle, where the data is presented. With no read, it returns to BUS_IDLE.

Top module: `hsem_bank`

## Requirements
- R1: After reset every lock is free with owner 0, every enable and status bit is 0, bus_rvalid is 0 and both interrupt lines are low.
- R2: The lock registers are at word addresses 0x00+n. Their read format is bit 31 = held and bits [3:0] = owner, with all other bits 0. A write with bit 31 set to a free lock takes it for the writer's bus_mid, and a read-back returns that ID.
- R3: A take write to a lock held by any master leaves the held flag and the owner unchanged, so the read-back shows the existing owner.
- R4: The claim registers are at 0x10+n. A read of a free lock returns held=1 with the reader's ID and leaves the lock held by the reader. A read of a held lock returns the current owner and changes nothing. Writes to claim registers are ignored.
- R5: A write with bit 31 clear frees the lock only when bus_mid equals the owner. A release from any other master is ignored.
- R6: A release by ID 1 sets lock n's bit in core 2's status. A release by ID 2 sets it in core 1's status. A release by any other ID sets no status bit.
- R7: The interrupt registers for core c (0 = core 1, 1 = core 2) are at 0x20+4c: enable (+0, read/write), status (+1, read-only), masked status (+2) and clear (+3, reads 0). Masked status equals status AND enable, and the core's interrupt line is the OR of its masked bits.
- R8: Writing 1 to a clear bit clears that status bit. Clear bits written as 0 change nothing, and writes to the status register are ignored.
- R9: Read data appears with bus_rvalid high exactly one cycle after the read request, and bus_rvalid is low otherwise. Unmapped addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | 4 | ID of the requesting bus master |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_core1 | output | 1 | Release interrupt for core 1 |
| irq_core2 | output | 1 | Release interrupt for core 2 |

## Verification
A wrong held flag or owner in a lock shows up on the next read of that lock's register. That read returns one cycle later, so an error is visible within two cycles of the faulty update. A status bit set in the wrong bank, or left standing after a clear, appears on the very next status read. When enabled, it also changes an interrupt line in the cycle after the edge that caused it. The sweep drives every lock through write-take, foreign take, foreign release, owner release and claim reads from both IDs. After each step it compares the bus answers against a model kept in the bench.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
    localparam int DATA_W    = 32;
    localparam int MID_W     = 4;
    localparam int NUM_CORES = 2;
    localparam int HELD_BIT  = 31;
    localparam logic [MID_W-1:0] CORE1_ID = 4'd1;
    localparam logic [MID_W-1:0] CORE2_ID = 4'd2;

    typedef enum logic {SEM_FREE, SEM_HELD} sem_state_e;
    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;
endpackage

// File: rtl/hsem_cell.sv
module hsem_cell
    import hsem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_wr,
    input  logic             free_wr,
    input  logic             take_rd,
    input  logic [MID_W-1:0] mid,
    output logic             locked,
    output logic [MID_W-1:0] owner,
    output logic             released
);
    sem_state_e       state_q, state_d;
    logic [MID_W-1:0] owner_q, owner_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            SEM_FREE: begin
                if (take_wr || take_rd) begin
                    state_d = SEM_HELD;
                    owner_d = mid;
                end
            end
            SEM_HELD: begin
                if (free_wr && (mid == owner_q)) begin
                    state_d = SEM_FREE;
                    owner_d = '0;
                end
            end
            default: begin
                state_d = SEM_FREE;
                owner_d = '0;
            end
        endcase
    end

    always_comb begin
        locked   = (state_q == SEM_HELD);
        owner    = owner_q;
        released = (state_q == SEM_HELD) && free_wr && (mid == owner_q);
    end

    a_r2_take_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && (take_wr || take_rd)) |=> (locked && owner == $past(mid)));

    a_r3_foreign_take_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && take_wr) |=> (locked && $stable(owner)));

    a_r5_foreign_free_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && free_wr && mid != owner) |=> (locked && $stable(owner)));
endmodule

// File: rtl/hsem_irq.sv
module hsem_irq
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic [NUM_SEM-1:0] en_wdata,
    input  logic               clr_we,
    input  logic [NUM_SEM-1:0] clr_wdata,
    input  logic [NUM_SEM-1:0] set_v,
    output logic [NUM_SEM-1:0] en,
    output logic [NUM_SEM-1:0] stat,
    output logic [NUM_SEM-1:0] mstat,
    output logic               irq
);
    logic [NUM_SEM-1:0] en_q, stat_q, clr_mask;

    always_comb clr_mask = clr_we ? clr_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (en_we) en_q <= en_wdata;
            stat_q <= (stat_q & ~clr_mask) | set_v;
        end
    end

    always_comb begin
        en    = en_q;
        stat  = stat_q;
        mstat = stat_q & en_q;
        irq   = |(stat_q & en_q);
    end

    a_r6_release_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((stat & $past(set_v)) == $past(set_v)));

    a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_v == '0) |=> ((stat & $past(clr_wdata)) == '0));
endmodule

// File: rtl/hsem_bus.sv
module hsem_bus
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 16,
    parameter int ADDR_W  = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [DATA_W-1:0]                   bus_wdata,
    input  logic [MID_W-1:0]                    bus_mid,
    input  logic [NUM_SEM-1:0]                  locked,
    input  logic [NUM_SEM-1:0][MID_W-1:0]       owner,
    input  logic [NUM_CORES-1:0][NUM_SEM-1:0]   en,
    input  logic [NUM_CORES-1:0][NUM_SEM-1:0]   stat,
    input  logic [NUM_CORES-1:0][NUM_SEM-1:0]   mstat,
    output logic [NUM_SEM-1:0]                  take_wr,
    output logic [NUM_SEM-1:0]                  free_wr,
    output logic [NUM_SEM-1:0]                  take_rd,
    output logic [NUM_CORES-1:0]                en_we,
    output logic [NUM_CORES-1:0]                clr_we,
    output logic [NUM_SEM-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                   bus_rdata,
    output logic                                bus_rvalid
);
    localparam int CLAIM_BASE = NUM_SEM;
    localparam int IRQ_BASE   = 2 * NUM_SEM;
    localparam int IRQ_REGS   = 4;

    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rd_word;
    logic              rd_req, wr_req;

    always_comb begin
        rd_req    = bus_sel && !bus_wr;
        wr_req    = bus_sel && bus_wr;
        reg_wdata = bus_wdata[NUM_SEM-1:0];
    end

    always_comb begin
        take_wr = '0;
        free_wr = '0;
        take_rd = '0;
        for (int k = 0; k < NUM_SEM; k++) begin
            if (int'(bus_addr) == k) begin
                take_wr[k] = wr_req && bus_wdata[HELD_BIT];
                free_wr[k] = wr_req && !bus_wdata[HELD_BIT];
            end
            if (int'(bus_addr) == CLAIM_BASE + k)
                take_rd[k] = rd_req;
        end
    end

    always_comb begin
        en_we  = '0;
        clr_we = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (int'(bus_addr) == IRQ_BASE + IRQ_REGS * c)     en_we[c]  = wr_req;
            if (int'(bus_addr) == IRQ_BASE + IRQ_REGS * c + 3) clr_we[c] = wr_req;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_SEM; k++) begin
            if (int'(bus_addr) == k) begin
                rd_word[HELD_BIT]  = locked[k];
                rd_word[MID_W-1:0] = owner[k];
            end
            if (int'(bus_addr) == CLAIM_BASE + k) begin
                rd_word[HELD_BIT]  = 1'b1;
                rd_word[MID_W-1:0] = locked[k] ? owner[k] : bus_mid;
            end
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (int'(bus_addr) == IRQ_BASE + IRQ_REGS * c)
                rd_word[NUM_SEM-1:0] = en[c];
            if (int'(bus_addr) == IRQ_BASE + IRQ_REGS * c + 1)
                rd_word[NUM_SEM-1:0] = stat[c];
            if (int'(bus_addr) == IRQ_BASE + IRQ_REGS * c + 2)
                rd_word[NUM_SEM-1:0] = mstat[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:               state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 16,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_mid,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_core1,
    output logic              irq_core2
);
    localparam int MAP_WORDS = 2 * NUM_SEM + 4 * NUM_CORES;

    initial begin
        if (MAP_WORDS > (1 << ADDR_W))
            $error("address width too small for the register map");
    end

    logic [NUM_SEM-1:0]                take_wr, free_wr, take_rd, released, locked;
    logic [NUM_SEM-1:0][MID_W-1:0]     owner;
    logic [NUM_CORES-1:0][NUM_SEM-1:0] en, stat, mstat, set_v;
    logic [NUM_CORES-1:0]              en_we, clr_we, irq;
    logic [NUM_SEM-1:0]                reg_wdata;

    hsem_bus #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_mid(bus_mid),
        .locked(locked), .owner(owner), .en(en), .stat(stat), .mstat(mstat),
        .take_wr(take_wr), .free_wr(free_wr), .take_rd(take_rd),
        .en_we(en_we), .clr_we(clr_we), .reg_wdata(reg_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        hsem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .take_wr(take_wr[s]), .free_wr(free_wr[s]), .take_rd(take_rd[s]),
            .mid(bus_mid),
            .locked(locked[s]), .owner(owner[s]), .released(released[s])
        );
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam logic [MID_W-1:0] PARTNER = (c == 0) ? CORE2_ID : CORE1_ID;
        always_comb set_v[c] = (bus_mid == PARTNER) ? released : '0;
        hsem_irq #(.NUM_SEM(NUM_SEM)) u_irq (
            .clk(clk), .rst_n(rst_n),
            .en_we(en_we[c]), .en_wdata(reg_wdata),
            .clr_we(clr_we[c]), .clr_wdata(reg_wdata),
            .set_v(set_v[c]),
            .en(en[c]), .stat(stat[c]), .mstat(mstat[c]), .irq(irq[c])
        );
    end

    always_comb begin
        irq_core1 = irq[0];
        irq_core2 = irq[1];
    end

    a_r6_foreign_id_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|released && bus_mid != CORE1_ID && bus_mid != CORE2_ID) |=> $stable(stat));
endmodule

// File: tb/hsem_bank_tb.sv
`timescale 1ns/1ps
module hsem_bank_tb;
    localparam int NS   = 16;
    localparam int CLM  = 16;
    localparam int IRQB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_mid = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq_core1, irq_core2;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] rd_val;
    logic [15:0] st_m [2];
    logic [15:0] en_m [2];

    always #10 clk = ~clk;

    hsem_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_core1(irq_core1), .irq_core2(irq_core2)
    );

    function automatic logic [31:0] held_word(input logic [3:0] id);
        return {1'b1, 27'd0, id};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int a, input logic [31:0] d, input logic [3:0] id);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d; bus_mid = id;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_rd(input int a, input logic [3:0] id);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a); bus_mid = id;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R9 rvalid with data", {31'd0, bus_rvalid}, 32'd1);
        rd_val = bus_rdata;
    endtask

    task automatic chk_irq_regs(input string tag);
        for (int c = 0; c < 2; c++) begin
            do_rd(IRQB + 4*c + 1, 4'd1);
            chk({tag, " status"}, rd_val, {16'd0, st_m[c]});
            do_rd(IRQB + 4*c + 2, 4'd1);
            chk({tag, " masked"}, rd_val, {16'd0, st_m[c] & en_m[c]});
        end
        chk({tag, " line1"}, {31'd0, irq_core1}, {31'd0, |(st_m[0] & en_m[0])});
        chk({tag, " line2"}, {31'd0, irq_core2}, {31'd0, |(st_m[1] & en_m[1])});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        st_m[0] = '0; st_m[1] = '0; en_m[0] = '0; en_m[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        chk("R1 irq1", {31'd0, irq_core1}, 32'd0);
        chk("R1 irq2", {31'd0, irq_core2}, 32'd0);
        for (int i = 0; i < NS; i++) begin
            do_rd(i, 4'd1);
            chk("R1 lock free", rd_val, 32'd0);
        end
        for (int c = 0; c < 2; c++) begin
            do_rd(IRQB + 4*c, 4'd1);
            chk("R1 enable", rd_val, 32'd0);
        end
        chk_irq_regs("R1");
        @(negedge clk);
        chk("R9 rvalid low when idle", {31'd0, bus_rvalid}, 32'd0);

        // sweep over every lock with both IDs
        for (int i = 0; i < NS; i++) begin
            logic [3:0] a, b;
            a = (i % 2 == 0) ? 4'd1 : 4'd2;
            b = 4'd3 - a;
            do_wr(i, 32'h8000_0000, a);
            do_rd(i, a);
            chk("R2 take by write", rd_val, held_word(a));
            do_wr(i, 32'h8000_0000, b);
            do_rd(i, b);
            chk("R3 foreign take", rd_val, held_word(a));
            do_wr(i, 32'h0, b);
            do_rd(i, b);
            chk("R5 foreign release", rd_val, held_word(a));
            do_wr(i, 32'h0, a);
            st_m[2 - a][i] = 1'b1;
            do_rd(i, a);
            chk("R5 owner release", rd_val, 32'd0);
            do_rd(CLM + i, b);
            chk("R4 claim free", rd_val, held_word(b));
            do_rd(CLM + i, a);
            chk("R4 claim held", rd_val, held_word(b));
            do_wr(CLM + i, 32'h0, b);
            do_rd(i, a);
            chk("R4 claim write ignored", rd_val, held_word(b));
            do_wr(i, 32'h0, b);
            st_m[2 - b][i] = 1'b1;
            chk_irq_regs("R6 release status");
        end

        // R7 enables and masking
        en_m[0] = 16'h00F0; en_m[1] = 16'h0003;
        do_wr(IRQB, 32'h0000_00F0, 4'd1);
        do_wr(IRQB + 4, 32'h0000_0003, 4'd2);
        do_rd(IRQB, 4'd1);
        chk("R7 enable core1", rd_val, 32'h0000_00F0);
        chk_irq_regs("R7 mask");

        // R8 clearing
        do_wr(IRQB + 3, 32'h0000_00F0, 4'd1);
        st_m[0] &= ~16'h00F0;
        chk_irq_regs("R8 clear ones");
        do_wr(IRQB + 4 + 3, 32'h0, 4'd1);
        chk_irq_regs("R8 clear zeros");
        do_wr(IRQB + 1, 32'h0, 4'd1);
        do_wr(IRQB + 4 + 1, 32'h0, 4'd1);
        chk_irq_regs("R8 status write ignored");
        do_rd(IRQB + 3, 4'd1);
        chk("R7 clear reads zero", rd_val, 32'd0);
        do_wr(IRQB + 3, 32'h0000_FFFF, 4'd1);
        do_wr(IRQB + 4 + 3, 32'h0000_FFFF, 4'd1);
        st_m[0] = '0; st_m[1] = '0;
        chk_irq_regs("R8 clear all");

        // R6 release by a third master sets nothing
        do_wr(5, 32'h8000_0000, 4'd3);
        do_rd(5, 4'd3);
        chk("R2 take by id3", rd_val, held_word(4'd3));
        do_wr(5, 32'h0, 4'd3);
        do_rd(5, 4'd3);
        chk("R5 id3 release", rd_val, 32'd0);
        chk_irq_regs("R6 id3 no status");

        // R9 unmapped space
        do_wr(6'h30, 32'hFFFF_FFFF, 4'd1);
        do_rd(6'h30, 4'd1);
        chk("R9 unmapped read", rd_val, 32'd0);
        do_rd(6'h3F, 4'd2);
        chk("R9 unmapped top", rd_val, 32'd0);
        chk_irq_regs("R9 unmapped write");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule